// File: doc/BRIEF.md
# Two-Stage Load-Balanced Cell Switch

This block is an N-port cell switch with no scheduler. It has two crossbar stages, and each one steps through a fixed rotating permutation once per clock. The clock cycle is the cell slot.

The first stage takes each external input and sends its cells to a different intermediate port in every slot. Over N slots, every input's traffic is therefore spread evenly across all N intermediate ports. Each intermediate port holds one small queue per destination output, so a cell waiting for a busy output never holds up cells bound elsewhere. The second stage connects each intermediate port to each output in turn. When intermediate port j faces output o, it hands over the oldest cell in its queue for o.

A cell is a valid bit, an output tag and a payload. The tag passes through the first stage unchanged and selects the queue. When a queue is full, an arriving cell is discarded and the drop counter of that intermediate port counts it. Cells may reach an output out of order with respect to other intermediate ports; putting them back in order is left to a later stage.

Top module: `lb_fabric`

## Requirements
- R1: While reset is high and on the first cycle after it falls, every `out_valid` bit is 0 and every drop counter reads 0.
- R2: Slot t counts clock cycles since reset fell, modulo N, and starts at 0. In slot t, a valid cell on input i is stored at intermediate port (i+t) mod N, in the queue selected by its unchanged tag.
- R3: In slot t, intermediate port j serves output (j+t) mod N. If that queue holds a cell at the start of the slot, the cell is removed and appears on `out_valid`/`out_pay` of that output on the next cycle.
- R4: Cells that share an intermediate port and a destination leave in the order they arrived.
- R5: If the queue served for an output is empty at the start of a slot, that output shows `out_valid` = 0 on the next cycle.
- R6: A cell is dropped if it arrives at a queue that already holds DEPTH cells, counted before any departure in the same slot. The drop counter of that intermediate port then rises by one on the next cycle and holds at its all-ones value.
- R7: A dropped cell never appears on any output. Summed over a burst, cells sent equal cells delivered plus drops.
- R8: Port k uses `in_dst[k*log2(N) +: log2(N)]`, `in_pay`/`out_pay[k*PAY_W +: PAY_W]` and `drop_cnt[k*CNT_W +: CNT_W]`. N is a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N | Cell present on each input |
| in_dst | input | N*log2(N) | Output tag of each input cell |
| in_pay | input | N*PAY_W | Payload of each input cell |
| out_valid | output | N | Cell present on each output |
| out_pay | output | N*PAY_W | Payload on each output |
| drop_cnt | output | N*CNT_W | Saturating drop count per intermediate port |

## Verification
Idle traffic checks that empty queues produce invalid slots. A single lone cell shows where the two rotations put it and when. A full-rate permutation, with each input steady on its own output, should run without any drop; this separates correct rotation offsets from wrong ones, because a wrong offset piles cells into a few queues. An all-to-one hotspot overflows the queues, which exercises drop accounting, the sent-equals-delivered-plus-dropped balance and counter saturation. Long random traffic, compared cycle by cycle against a behavioural queue model, exposes any reordering or wrong queue selection.

// File: rtl/lb_pkg.sv
package lb_pkg;

    localparam int unsigned DEF_PORTS = 4;
    localparam int unsigned DEF_PAY_W = 8;
    localparam int unsigned DEF_DEPTH = 4;
    localparam int unsigned DEF_CNT_W = 8;

    // (a + b) mod n
    function automatic int unsigned wrap_add(int unsigned a, int unsigned b, int unsigned n);
        return (a + b) % n;
    endfunction

    // (a - b) mod n, b already below n
    function automatic int unsigned wrap_sub(int unsigned a, int unsigned b, int unsigned n);
        return (a + n - (b % n)) % n;
    endfunction

endpackage

// File: rtl/lb_slot_ctr.sv
module lb_slot_ctr #(
    parameter int unsigned N = lb_pkg::DEF_PORTS,
    localparam int unsigned SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [SW-1:0] slot
);
    always_ff @(posedge clk) begin
        if (rst)                      slot <= '0;
        else if (slot == SW'(N - 1))  slot <= '0;
        else                          slot <= slot + SW'(1);
    end

    p_slot_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (slot == SW'(N - 1)) |=> (slot == '0));

    p_slot_step_r2: assert property (@(posedge clk) disable iff (rst)
        (slot != SW'(N - 1)) |=> (slot == $past(slot) + SW'(1)));
endmodule

// File: rtl/lb_rotator.sv
module lb_rotator #(
    parameter int unsigned N = lb_pkg::DEF_PORTS,
    parameter int unsigned W = 8,
    localparam int unsigned SW = $clog2(N)
) (
    input  logic [SW-1:0]         shift,
    input  logic [N-1:0][W-1:0]   din,
    output logic [N-1:0][W-1:0]   dout
);
    import lb_pkg::*;

    // output o takes input (o - shift) mod N, i.e. input i lands on (i + shift) mod N
    for (genvar o = 0; o < N; o++) begin : g_lane
        logic [SW-1:0] src;
        always_comb begin
            src     = SW'(wrap_sub(o, 32'(shift), N));
            dout[o] = din[src];
        end
    end
endmodule

// File: rtl/lb_voq.sv
module lb_voq #(
    parameter int unsigned DEPTH = lb_pkg::DEF_DEPTH,
    parameter int unsigned W     = lb_pkg::DEF_PAY_W,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    function automatic logic [AW-1:0] next_ptr(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= next_ptr(wr_ptr);
            end
            if (pop) rd_ptr <= next_ptr(rd_ptr);
            if (push && !pop)      count <= count + CW'(1);
            else if (pop && !push) count <= count - CW'(1);
        end
    end

    assign dout  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));

    p_push_room_r6: assert property (@(posedge clk) disable iff (rst) push |-> !full);
    p_pop_filled_r5: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/lb_mid_port.sv
module lb_mid_port #(
    parameter int unsigned PORT_ID = 0,
    parameter int unsigned N       = lb_pkg::DEF_PORTS,
    parameter int unsigned PAY_W   = lb_pkg::DEF_PAY_W,
    parameter int unsigned DEPTH   = lb_pkg::DEF_DEPTH,
    parameter int unsigned CNT_W   = lb_pkg::DEF_CNT_W,
    localparam int unsigned SW     = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SW-1:0]    slot,
    input  logic             in_valid,
    input  logic [SW-1:0]    in_dst,
    input  logic [PAY_W-1:0] in_pay,
    output logic             out_valid,
    output logic [PAY_W-1:0] out_pay,
    output logic [CNT_W-1:0] drop_cnt
);
    import lb_pkg::*;

    logic [SW-1:0]             serve;
    logic [N-1:0]              q_full, q_empty, q_push, q_pop;
    logic [N-1:0][PAY_W-1:0]   q_head;
    logic                      hit_full;

    // second-stage connection for this port in the current slot
    assign serve = SW'(wrap_add(PORT_ID, 32'(slot), N));

    for (genvar k = 0; k < N; k++) begin : g_voq
        lb_voq #(.DEPTH(DEPTH), .W(PAY_W)) u_q (
            .clk   (clk),
            .rst   (rst),
            .push  (q_push[k]),
            .din   (in_pay),
            .pop   (q_pop[k]),
            .dout  (q_head[k]),
            .empty (q_empty[k]),
            .full  (q_full[k])
        );
        assign q_push[k] = in_valid && (in_dst == SW'(k)) && !q_full[k];
        assign q_pop[k]  = (serve == SW'(k)) && !q_empty[k];
    end

    assign out_valid = !q_empty[serve];
    assign out_pay   = q_head[serve];
    assign hit_full  = in_valid && q_full[in_dst];

    always_ff @(posedge clk) begin
        if (rst)                          drop_cnt <= '0;
        else if (hit_full && ~&drop_cnt)  drop_cnt <= drop_cnt + CNT_W'(1);
    end

    p_drop_step_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && q_full[in_dst] && (drop_cnt != '1)) |=> (drop_cnt == $past(drop_cnt) + CNT_W'(1)));

    p_drop_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && q_full[in_dst]) |=> $stable(drop_cnt));
endmodule

// File: rtl/lb_fabric.sv
module lb_fabric #(
    parameter int unsigned N     = lb_pkg::DEF_PORTS,
    parameter int unsigned PAY_W = lb_pkg::DEF_PAY_W,
    parameter int unsigned DEPTH = lb_pkg::DEF_DEPTH,
    parameter int unsigned CNT_W = lb_pkg::DEF_CNT_W,
    localparam int unsigned SW   = $clog2(N)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N-1:0]       in_valid,
    input  logic [N*SW-1:0]    in_dst,
    input  logic [N*PAY_W-1:0] in_pay,
    output logic [N-1:0]       out_valid,
    output logic [N*PAY_W-1:0] out_pay,
    output logic [N*CNT_W-1:0] drop_cnt
);
    typedef struct packed {
        logic             valid;
        logic [SW-1:0]    dst;
        logic [PAY_W-1:0] pay;
    } tagged_cell_t;

    typedef struct packed {
        logic             valid;
        logic [PAY_W-1:0] pay;
    } out_cell_t;

    localparam int unsigned TW = $bits(tagged_cell_t);
    localparam int unsigned OW = $bits(out_cell_t);

    logic [SW-1:0]      slot;
    tagged_cell_t [N-1:0] in_cells, mid_cells;
    out_cell_t    [N-1:0] mid_out, routed, out_q;
    logic [N-1:0][CNT_W-1:0] mid_drop;

    lb_slot_ctr #(.N(N)) u_slot (.clk(clk), .rst(rst), .slot(slot));

    for (genvar i = 0; i < N; i++) begin : g_in
        assign in_cells[i].valid = in_valid[i];
        assign in_cells[i].dst   = in_dst[i*SW +: SW];
        assign in_cells[i].pay   = in_pay[i*PAY_W +: PAY_W];
    end

    // stage one: input i -> intermediate (i + slot) mod N
    lb_rotator #(.N(N), .W(TW)) u_stage1 (
        .shift (slot),
        .din   (in_cells),
        .dout  (mid_cells)
    );

    for (genvar j = 0; j < N; j++) begin : g_mid
        lb_mid_port #(
            .PORT_ID (j),
            .N       (N),
            .PAY_W   (PAY_W),
            .DEPTH   (DEPTH),
            .CNT_W   (CNT_W)
        ) u_mid (
            .clk       (clk),
            .rst       (rst),
            .slot      (slot),
            .in_valid  (mid_cells[j].valid),
            .in_dst    (mid_cells[j].dst),
            .in_pay    (mid_cells[j].pay),
            .out_valid (mid_out[j].valid),
            .out_pay   (mid_out[j].pay),
            .drop_cnt  (mid_drop[j])
        );
        assign drop_cnt[j*CNT_W +: CNT_W] = mid_drop[j];
    end

    // stage two: intermediate j -> output (j + slot) mod N
    lb_rotator #(.N(N), .W(OW)) u_stage2 (
        .shift (slot),
        .din   (mid_out),
        .dout  (routed)
    );

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= routed;
    end

    for (genvar o = 0; o < N; o++) begin : g_out
        assign out_valid[o]               = out_q[o].valid;
        assign out_pay[o*PAY_W +: PAY_W]  = out_q[o].pay;
    end
endmodule

// File: tb/sim_lb_fabric.sv
`timescale 1ns/1ps
module sim_lb_fabric;
    localparam int NP = 4;
    localparam int PW = 8;
    localparam int DP = 4;
    localparam int CW = 8;
    localparam int SW = 2;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NP-1:0]    in_valid;
    logic [NP*SW-1:0] in_dst;
    logic [NP*PW-1:0] in_pay;
    logic [NP-1:0]    out_valid;
    logic [NP*PW-1:0] out_pay;
    logic [NP*CW-1:0] drop_cnt;

    lb_fabric #(.N(NP), .PAY_W(PW), .DEPTH(DP), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_dst(in_dst), .in_pay(in_pay),
        .out_valid(out_valid), .out_pay(out_pay), .drop_cnt(drop_cnt)
    );

    always #2.5 clk = ~clk;

    int total = 0, bad = 0;
    int tslot = 0;
    bit expv[NP];
    int expp[NP];
    int mdrop[NP];
    int mq[NP][NP][$];
    bit dv[NP];
    int dd[NP];
    int dp[NP];
    int paycnt = 1;
    int sent = 0, delivered = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic setcell(input int i, input bit v, input int d);
        dv[i] = v;
        dd[i] = d;
        dp[i] = paycnt;
        if (v) paycnt = (paycnt + 1) % 256;
    endtask

    task automatic idle_all();
        for (int i = 0; i < NP; i++) setcell(i, 0, 0);
    endtask

    // called at a falling edge: compare, drive, advance model, wait next falling edge
    task automatic step();
        bit fullpre[NP][NP];
        for (int o = 0; o < NP; o++) begin
            if (expv[o]) check(out_valid[o] === 1'b1, "R2 R3", $sformatf("valid out%0d", o), int'(out_valid[o]), 1);
            else         check(out_valid[o] === 1'b0, "R5", $sformatf("idle out%0d", o), int'(out_valid[o]), 0);
            if (expv[o] && out_valid[o] === 1'b1)
                check(int'(out_pay[o*PW +: PW]) == expp[o], "R4 R8", $sformatf("payload out%0d", o),
                      int'(out_pay[o*PW +: PW]), expp[o]);
            if (out_valid[o] === 1'b1) delivered++;
        end
        for (int j = 0; j < NP; j++)
            check(int'(drop_cnt[j*CW +: CW]) == mdrop[j], "R6", $sformatf("drops mid%0d", j),
                  int'(drop_cnt[j*CW +: CW]), mdrop[j]);
        // R8: flattened field positions
        for (int i = 0; i < NP; i++) begin
            in_valid[i]           = dv[i];
            in_dst[i*SW +: SW]    = SW'(dd[i]);
            in_pay[i*PW +: PW]    = PW'(dp[i]);
            if (dv[i]) sent++;
        end
        for (int j = 0; j < NP; j++)
            for (int d = 0; d < NP; d++) fullpre[j][d] = (mq[j][d].size() >= DP);
        for (int j = 0; j < NP; j++) begin
            int o = (j + tslot) % NP;
            if (mq[j][o].size() > 0) begin
                expv[o] = 1;
                expp[o] = mq[j][o].pop_front();
            end else begin
                expv[o] = 0;
            end
        end
        for (int i = 0; i < NP; i++) begin
            if (dv[i]) begin
                int j = (i + tslot) % NP;
                if (fullpre[j][dd[i]]) begin
                    if (mdrop[j] < CMAX) mdrop[j]++;
                end else begin
                    mq[j][dd[i]].push_back(dp[i]);
                end
            end
        end
        tslot = (tslot + 1) % NP;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int s0, d0, dr0, dr1;
        in_valid = '0;
        in_dst   = '0;
        in_pay   = '0;
        for (int o = 0; o < NP; o++) begin expv[o] = 0; expp[o] = 0; mdrop[o] = 0; end
        idle_all();
        repeat (4) @(negedge clk);
        // R1: reset state
        check(out_valid === '0, "R1", "out_valid in reset", int'(out_valid), 0);
        check(drop_cnt === '0, "R1", "drop_cnt in reset", int'(drop_cnt), 0);
        rst = 1'b0;

        // idle pattern (R5)
        repeat (6) step();

        // lone cell, input 1 to output 3 (R2 R3)
        setcell(1, 1, 3);
        step();
        idle_all();
        repeat (8) step();

        // full-rate permutation: input i always to output (i+2) mod N, never drops (R6)
        for (int c = 0; c < 80; c++) begin
            for (int i = 0; i < NP; i++) setcell(i, 1, (i + 2) % NP);
            step();
        end
        idle_all();
        repeat (3 * DP) step();
        check(int'(drop_cnt) == 0, "R6", "no drops for admissible permutation", int'(drop_cnt), 0);

        // short hotspot: balance of sent, delivered and dropped (R7)
        s0 = sent; d0 = delivered; dr0 = 0;
        for (int j = 0; j < NP; j++) dr0 += int'(drop_cnt[j*CW +: CW]);
        for (int c = 0; c < 40; c++) begin
            for (int i = 0; i < NP; i++) setcell(i, 1, 0);
            step();
        end
        idle_all();
        repeat (NP * DP + 4) step();
        dr1 = 0;
        for (int j = 0; j < NP; j++) dr1 += int'(drop_cnt[j*CW +: CW]);
        check((sent - s0) == (delivered - d0) + (dr1 - dr0), "R7", "sent vs delivered+dropped",
              (delivered - d0) + (dr1 - dr0), sent - s0);
        check(dr1 > dr0, "R6", "hotspot causes drops", dr1 - dr0, 1);

        // random traffic
        for (int c = 0; c < 2000; c++) begin
            for (int i = 0; i < NP; i++) setcell(i, bit'($urandom_range(0, 1)), $urandom_range(0, NP - 1));
            step();
        end

        // long hotspot to saturate the counters (R6)
        for (int c = 0; c < 500; c++) begin
            for (int i = 0; i < NP; i++) setcell(i, 1, 1);
            step();
        end
        idle_all();
        repeat (NP * DP + 4) step();
        for (int j = 0; j < NP; j++)
            check(int'(drop_cnt[j*CW +: CW]) == CMAX, "R6", $sformatf("saturated mid%0d", j),
                  int'(drop_cnt[j*CW +: CW]), CMAX);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule